// File: doc/BRIEF.md
# Auto-Incrementing I2C Register Slave

This block is the control-port end of a sound-decoder chip. An external bus master reaches it over a two-wire I2C bus. SCL and SDA are oversampled by the chip clock. SDA is driven only through an open-drain enable, which pulls the line low.

The device address is 101101X. The low address bit X follows a strap input, so two such chips can share one bus. A write transaction sends a sub-address, then any number of data bytes. The data bytes fill five configuration registers in turn, and the pointer wraps from the last register back to the first.

A read transaction always begins at the first of five status bytes and steps through them in a fixed order. Several of these status bits are sticky flags. A flag is cleared only when the master has clocked in the acknowledge bit (ACK or NACK) for the byte that carries it.

Top module: `autoinc_i2c_regs`

## Requirements
- R1: A transaction is accepted (ACK driven in the ninth clock) only when the seven address bits equal 1,0,1,1,0,1,X, with X equal to `addr_sel_i`. Any other address gets no ACK and has no effect on the registers.
- R2: In a write, the first byte after the address is the sub-address. Each following byte is stored in the register at the pointer, and the pointer then advances by one. The slave ACKs every byte. `cfg_o[8*k+7:8*k]` holds register k.
- R3: After a byte is stored at sub-address 4, the next byte goes to sub-address 0.
- R4: If the pointer holds a sub-address above 4, data bytes are still ACKed but are discarded, and the pointer does not move.
- R5: Reset loads the following register values:
  - register 0 = 0x02: bit0 port output = 0, bit1 digital-audio enable = 1, bits5:2 FM attenuation = 0000.
  - register 1 = 0x03: bit0 system select = 1, bit1 auto-standard = 1, bit2 standard lock = 0.
  - register 2 = 0x00.
  - register 3 (upper error limit) = 0x50.
  - register 4 (lower error limit) = 0x14.
- R6: Every read starts at byte 0 and returns bytes in this order:
  - byte 0: status 1 = {power-on flag, `stat1_i[5:0]`, configuration flag}.
  - byte 1: `err_cnt_i`.
  - byte 2: auxiliary bits 7:0.
  - byte 3: {overwrite flag, new-data flag, 000, auxiliary bits 10:8}.
  - byte 4: `stat2_i`.
- R7: Bit 7 of status 1 (power-on flag) is 1 after reset and becomes 0 once the master has acknowledged or NACKed status 1.
- R8: A `cfg_chg_i` pulse drives bit 0 of status 1 to 0 (active-low configuration change). The bit returns to 1 once status 1 has been acknowledged or NACKed.
- R9: An `aux_stb_i` pulse captures `aux_i` and sets the new-data flag (byte 3 bit 6). The flag clears once byte 3 has been acknowledged or NACKed. A read that ends earlier leaves the flag set.
- R10: A capture that arrives while the new-data flag is still set also sets the overwrite flag (byte 3 bit 7). The overwrite flag clears together with the new-data flag.
- R11: `sda_oe_o` changes only while SCL is low.
- R12: A stop condition releases SDA and ends the transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | chip clock used to oversample the bus |
| rst_n | input | 1 | active-low reset, loads defaults |
| scl_i | input | 1 | bus clock line level |
| sda_i | input | 1 | bus data line level |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| addr_sel_i | input | 1 | strap giving the address LSB |
| cfg_o | output | 40 | five configuration registers, register k in bits 8k+7:8k |
| stat1_i | input | 6 | core status for status 1 bits 6:1 |
| err_cnt_i | input | 8 | core error count for byte 1 |
| aux_stb_i | input | 1 | one-cycle pulse that captures auxiliary data |
| aux_i | input | 11 | auxiliary data bits |
| stat2_i | input | 8 | core status for byte 4 |
| cfg_chg_i | input | 1 | one-cycle pulse marking a configuration change |

## Verification
The hardest situations to reach are those that depend on how far a read got before the master stopped. A sticky flag must survive a read that ends before its byte, and must clear only after the acknowledge bit of the byte that carries it. The directed tests drive this with reads of one and of four bytes, each ended by a NACK and placed between core pulses. The overwrite case uses two captures with no read in between. The wrap case starts a write at sub-address 3, so the third byte lands in register 0.

// File: rtl/aic_pkg.sv
package aic_pkg;
   typedef enum logic [2:0] {
      ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
   } eng_state_e;
   localparam int RD_BYTES = 5;
   localparam logic [5:0] DEV_ADDR_HI = 6'b101101;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [SYNC_STAGES-1:0] scl_sh, sda_sh;
   logic scl_p, sda_p;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_p  <= 1'b1;
         sda_p  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[SYNC_STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[SYNC_STAGES-2:0], sda_i};
         scl_p  <= scl_sh[SYNC_STAGES-1];
         sda_p  <= sda_sh[SYNC_STAGES-1];
      end
   end

   assign scl_s     = scl_sh[SYNC_STAGES-1];
   assign sda_s     = sda_sh[SYNC_STAGES-1];
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
   import aic_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sda_s,
   input  logic       scl_rise,
   input  logic       scl_fall,
   input  logic       start_det,
   input  logic       stop_det,
   input  logic       addr_sel_i,
   input  logic [7:0] tx_byte,
   output logic       sda_oe,
   output logic       addr_rd_stb,
   output logic       rx_stb,
   output logic       rx_sub,
   output logic [7:0] rx_data,
   output logic       rd_ack_stb
);
   eng_state_e state;
   logic [3:0] cnt;
   logic [7:0] sh;
   logic       is_rd, first, mack;

   assign rx_data = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cnt         <= '0;
         sh          <= '0;
         is_rd       <= 1'b0;
         first       <= 1'b0;
         mack        <= 1'b0;
         sda_oe      <= 1'b0;
         addr_rd_stb <= 1'b0;
         rx_stb      <= 1'b0;
         rx_sub      <= 1'b0;
         rd_ack_stb  <= 1'b0;
      end else begin
         addr_rd_stb <= 1'b0;
         rx_stb      <= 1'b0;
         rd_ack_stb  <= 1'b0;
         if (start_det) begin
            state  <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else begin
            unique case (state)
               ST_ADDR, ST_WR: begin
                  if (scl_rise && cnt < 4'd8) begin
                     sh  <= {sh[6:0], sda_s};
                     cnt <= cnt + 4'd1;
                  end
                  if (scl_fall && cnt == 4'd8) begin
                     if (state == ST_ADDR) begin
                        if (sh[7:1] == {DEV_ADDR_HI, addr_sel_i}) begin
                           sda_oe      <= 1'b1;
                           is_rd       <= sh[0];
                           first       <= 1'b1;
                           addr_rd_stb <= sh[0];
                           state       <= ST_AACK;
                        end else begin
                           state <= ST_IDLE;
                        end
                     end else begin
                        sda_oe <= 1'b1;
                        rx_stb <= 1'b1;
                        rx_sub <= first;
                        first  <= 1'b0;
                        state  <= ST_WACK;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     if (is_rd) begin
                        sh     <= tx_byte;
                        sda_oe <= ~tx_byte[7];
                        cnt    <= 4'd1;
                        state  <= ST_RD;
                     end else begin
                        sda_oe <= 1'b0;
                        cnt    <= '0;
                        state  <= ST_WR;
                     end
                  end
               end
               ST_WACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     cnt    <= '0;
                     state  <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_fall) begin
                     if (cnt == 4'd8) begin
                        sda_oe <= 1'b0;
                        state  <= ST_RACK;
                     end else begin
                        sh     <= {sh[6:0], 1'b0};
                        sda_oe <= ~sh[6];
                        cnt    <= cnt + 4'd1;
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     rd_ack_stb <= 1'b1;
                     mack       <= ~sda_s;
                  end
                  if (scl_fall) begin
                     if (mack) begin
                        sh     <= tx_byte;
                        sda_oe <= ~tx_byte[7];
                        cnt    <= 4'd1;
                        state  <= ST_RD;
                     end else begin
                        state <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/autoinc_reg_bank.sv
module autoinc_reg_bank
   import aic_pkg::*;
#(
   parameter int NREG = 5,
   parameter int AUXW = 11,
   parameter logic [NREG*8-1:0] REG_RST = 40'h14_50_00_03_02
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_stb,
   input  logic            rx_sub,
   input  logic [7:0]      rx_data,
   input  logic            addr_rd_stb,
   input  logic            rd_ack_stb,
   input  logic [5:0]      stat1_i,
   input  logic [7:0]      err_cnt_i,
   input  logic            aux_stb_i,
   input  logic [AUXW-1:0] aux_i,
   input  logic [7:0]      stat2_i,
   input  logic            cfg_chg_i,
   output logic [NREG*8-1:0] cfg_o,
   output logic [7:0]      tx_byte,
   output logic            por_flag,
   output logic            ovw_flag
);
   localparam int RPW = $clog2(RD_BYTES);
   localparam int AUX_HI = AUXW - 8;

   logic [7:0]      regs_q [NREG];
   logic [7:0]      sub_q;
   logic [RPW-1:0]  rd_ptr;
   logic            cfg_n_q, newd_q;
   logic [AUXW-1:0] aux_q;
   logic            clr_s1, clr_aux;

   generate
      if (NREG < 2 || NREG > 255) begin : g_bad_nreg
         $error("NREG out of range");
      end
      if (AUXW < 9 || AUXW > 13) begin : g_bad_auxw
         $error("AUXW must be 9 to 13");
      end
      for (genvar g = 0; g < NREG; g++) begin : g_out
         assign cfg_o[g*8 +: 8] = regs_q[g];
      end
   endgenerate

   assign clr_s1  = rd_ack_stb && (rd_ptr == RPW'(0));
   assign clr_aux = rd_ack_stb && (rd_ptr == RPW'(3));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < NREG; i++) regs_q[i] <= REG_RST[i*8 +: 8];
         sub_q <= '0;
      end else if (rx_stb) begin
         if (rx_sub) begin
            sub_q <= rx_data;
         end else if (int'(sub_q) < NREG) begin
            regs_q[sub_q] <= rx_data;
            sub_q <= (sub_q == 8'(NREG-1)) ? 8'd0 : sub_q + 8'd1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_ptr   <= '0;
         por_flag <= 1'b1;
         cfg_n_q  <= 1'b1;
         newd_q   <= 1'b0;
         ovw_flag <= 1'b0;
         aux_q    <= '0;
      end else begin
         if (addr_rd_stb) rd_ptr <= '0;
         else if (rd_ack_stb)
            rd_ptr <= (rd_ptr == RPW'(RD_BYTES-1)) ? '0 : rd_ptr + RPW'(1);
         if (clr_s1) por_flag <= 1'b0;
         if (cfg_chg_i) cfg_n_q <= 1'b0;
         else if (clr_s1) cfg_n_q <= 1'b1;
         if (aux_stb_i) begin
            aux_q    <= aux_i;
            newd_q   <= 1'b1;
            ovw_flag <= clr_aux ? 1'b0 : (ovw_flag | newd_q);
         end else if (clr_aux) begin
            newd_q   <= 1'b0;
            ovw_flag <= 1'b0;
         end
      end
   end

   always_comb begin
      case (rd_ptr)
         RPW'(0): tx_byte = {por_flag, stat1_i, cfg_n_q};
         RPW'(1): tx_byte = err_cnt_i;
         RPW'(2): tx_byte = aux_q[7:0];
         RPW'(3): tx_byte = {ovw_flag, newd_q, {(6-AUX_HI){1'b0}}, aux_q[AUXW-1:8]};
         default: tx_byte = stat2_i;
      endcase
   end
endmodule

// File: rtl/autoinc_i2c_regs.sv
module autoinc_i2c_regs
   import aic_pkg::*;
#(
   parameter int NREG = 5,
   parameter int AUXW = 11,
   parameter int SYNC_STAGES = 2,
   parameter logic [NREG*8-1:0] REG_RST = 40'h14_50_00_03_02
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe_o,
   input  logic              addr_sel_i,
   output logic [NREG*8-1:0] cfg_o,
   input  logic [5:0]        stat1_i,
   input  logic [7:0]        err_cnt_i,
   input  logic              aux_stb_i,
   input  logic [AUXW-1:0]   aux_i,
   input  logic [7:0]        stat2_i,
   input  logic              cfg_chg_i
);
   logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic addr_rd_stb, rx_stb, rx_sub, rd_ack_stb, por_flag, ovw_flag;
   logic [7:0] rx_data, tx_byte;

   i2c_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_smp (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det));

   i2c_byte_engine u_eng (
      .clk(clk), .rst_n(rst_n), .sda_s(sda_s), .scl_rise(scl_rise),
      .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
      .addr_sel_i(addr_sel_i), .tx_byte(tx_byte), .sda_oe(sda_oe_o),
      .addr_rd_stb(addr_rd_stb), .rx_stb(rx_stb), .rx_sub(rx_sub),
      .rx_data(rx_data), .rd_ack_stb(rd_ack_stb));

   autoinc_reg_bank #(.NREG(NREG), .AUXW(AUXW), .REG_RST(REG_RST)) u_bank (
      .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_sub(rx_sub),
      .rx_data(rx_data), .addr_rd_stb(addr_rd_stb), .rd_ack_stb(rd_ack_stb),
      .stat1_i(stat1_i), .err_cnt_i(err_cnt_i), .aux_stb_i(aux_stb_i),
      .aux_i(aux_i), .stat2_i(stat2_i), .cfg_chg_i(cfg_chg_i),
      .cfg_o(cfg_o), .tx_byte(tx_byte), .por_flag(por_flag), .ovw_flag(ovw_flag));
endmodule

// File: rtl/autoinc_i2c_regs_chk.sv
module autoinc_i2c_regs_chk #(
   parameter int CW = 40
) (
   input logic          clk,
   input logic          rst_n,
   input logic          scl_i,
   input logic          sda_oe_o,
   input logic [CW-1:0] cfg_o,
   input logic          rx_stb,
   input logic          por_flag,
   input logic          ovw_flag,
   input logic          aux_stb_i,
   input logic          stop_det
);
   // R11
   sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe_o) |-> !scl_i);
   // R2
   cfg_from_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cfg_o) |-> $past(rx_stb));
   // R7
   por_no_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(por_flag));
   // R10
   ovw_from_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovw_flag) |-> $past(aux_stb_i));
   // R12
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe_o);
endmodule

bind autoinc_i2c_regs autoinc_i2c_regs_chk #(.CW(NREG*8)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe_o(sda_oe_o),
   .cfg_o(cfg_o), .rx_stb(rx_stb), .por_flag(por_flag),
   .ovw_flag(ovw_flag), .aux_stb_i(aux_stb_i), .stop_det(stop_det));

// File: tb/autoinc_i2c_regs_tb_top.sv
module autoinc_i2c_regs_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int Q = 8;
   localparam int WD_CYCLES = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_sda = 1'b1;
   logic sda_oe, addr_sel = 1'b0;
   logic [39:0] cfg;
   logic [5:0] stat1 = 6'b101001;
   logic [7:0] errc = 8'h7E, stat2 = 8'h96;
   logic aux_stb = 1'b0, cfg_chg = 1'b0;
   logic [10:0] aux = '0;
   wire sda_line = m_sda & ~sda_oe;

   int checks = 0, bad = 0, hi_edges = 0;
   logic prev_oe = 1'b0;
   logic [7:0] wd [5];
   logic [7:0] rb [5];

   always #(CLK_PERIOD/2) clk = ~clk;

   autoinc_i2c_regs dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .addr_sel_i(addr_sel), .cfg_o(cfg),
      .stat1_i(stat1), .err_cnt_i(errc), .aux_stb_i(aux_stb), .aux_i(aux),
      .stat2_i(stat2), .cfg_chg_i(cfg_chg));

   always @(posedge clk) begin
      if (sda_oe !== prev_oe && scl) hi_edges++;
      prev_oe <= sda_oe;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      m_sda = 1'b1; scl = 1'b1; wclk(2*Q);
      m_sda = 1'b0; wclk(2*Q);
      scl = 1'b0; wclk(Q);
   endtask

   task automatic bus_stop();
      m_sda = 1'b0; wclk(Q);
      scl = 1'b1; wclk(2*Q);
      m_sda = 1'b1; wclk(2*Q);
   endtask

   task automatic put_bit(input logic b);
      m_sda = b; wclk(Q);
      scl = 1'b1; wclk(2*Q);
      scl = 1'b0; wclk(Q);
   endtask

   task automatic get_bit(output logic b);
      m_sda = 1'b1; wclk(Q);
      scl = 1'b1; wclk(Q);
      b = sda_line; wclk(Q);
      scl = 1'b0; wclk(Q);
   endtask

   task automatic put_byte(input logic [7:0] v, output logic ack);
      logic l;
      for (int i = 7; i >= 0; i--) put_bit(v[i]);
      get_bit(l);
      ack = ~l;
   endtask

   task automatic get_byte(output logic [7:0] v, input logic ack);
      logic l;
      for (int i = 7; i >= 0; i--) begin
         get_bit(l);
         v[i] = l;
      end
      put_bit(~ack);
   endtask

   task automatic do_write(input logic [6:0] a, input logic [7:0] sub, input int n,
                           output logic a_ack, output logic all_ack);
      logic k;
      bus_start();
      put_byte({a, 1'b0}, a_ack);
      all_ack = a_ack;
      if (a_ack) begin
         put_byte(sub, k); all_ack &= k;
         for (int i = 0; i < n; i++) begin
            put_byte(wd[i], k);
            all_ack &= k;
         end
      end
      bus_stop();
   endtask

   task automatic do_read(input int n, output logic a_ack);
      bus_start();
      put_byte({7'b1011010 | {6'd0, addr_sel}, 1'b1}, a_ack);
      if (a_ack)
         for (int i = 0; i < n; i++) get_byte(rb[i], i != n-1);
      bus_stop();
   endtask

   task automatic pulse_aux(input logic [10:0] v);
      @(negedge clk); aux = v; aux_stb = 1'b1;
      @(negedge clk); aux_stb = 1'b0;
   endtask

   task automatic t_reset();
      chk("R5 defaults", cfg, 40'h14_50_00_03_02);
      chk("R12 idle line", sda_oe, 1'b0);
   endtask

   task automatic t_read_order();
      logic a;
      do_read(5, a);
      chk("R6 addr ack", a, 1'b1);
      chk("R7 status1 por set", rb[0], 8'hD3);
      chk("R6 error byte", rb[1], 8'h7E);
      chk("R6 aux byte0", rb[2], 8'h00);
      chk("R6 aux byte1", rb[3], 8'h00);
      chk("R6 status2", rb[4], 8'h96);
      do_read(1, a);
      chk("R7 por cleared, read restarts at status1", rb[0], 8'h53);
      chk("R12 released after stop", sda_oe, 1'b0);
   endtask

   task automatic t_burst();
      logic a, all;
      wd[0] = 8'h11; wd[1] = 8'h22; wd[2] = 8'h33; wd[3] = 8'h44; wd[4] = 8'h55;
      do_write(7'h5A, 8'h00, 5, a, all);
      chk("R2 all bytes acked", all, 1'b1);
      chk("R2 burst stored", cfg, 40'h55_44_33_22_11);
   endtask

   task automatic t_wrap();
      logic a, all;
      wd[0] = 8'hA1; wd[1] = 8'hB2; wd[2] = 8'hC3;
      do_write(7'h5A, 8'h03, 3, a, all);
      chk("R3 wrap acked", all, 1'b1);
      chk("R3 wrap to reg0", cfg, 40'hB2_A1_33_22_C3);
   endtask

   task automatic t_bad_sub();
      logic a, all;
      wd[0] = 8'h99; wd[1] = 8'h88;
      do_write(7'h5A, 8'h07, 2, a, all);
      chk("R4 out-of-range acked", all, 1'b1);
      chk("R4 out-of-range discarded", cfg, 40'hB2_A1_33_22_C3);
   endtask

   task automatic t_addr();
      logic a, all;
      wd[0] = 8'h77;
      do_write(7'h5B, 8'h00, 1, a, all);
      chk("R1 wrong address nacked", a, 1'b0);
      chk("R1 wrong address no effect", cfg, 40'hB2_A1_33_22_C3);
      addr_sel = 1'b1;
      do_write(7'h5A, 8'h00, 1, a, all);
      chk("R1 strap moves address", a, 1'b0);
      do_write(7'h5B, 8'h02, 1, a, all);
      chk("R1 strapped address acked", all, 1'b1);
      chk("R1 strapped write", cfg, 40'hB2_A1_77_22_C3);
      addr_sel = 1'b0;
   endtask

   task automatic t_cfg_flag();
      logic a;
      @(negedge clk); cfg_chg = 1'b1;
      @(negedge clk); cfg_chg = 1'b0;
      do_read(1, a);
      chk("R8 change flag low", rb[0], 8'h52);
      do_read(1, a);
      chk("R8 change flag restored", rb[0], 8'h53);
   endtask

   task automatic t_aux();
      logic a;
      pulse_aux(11'h5A3);
      do_read(1, a);
      chk("R9 short read status", rb[0], 8'h53);
      do_read(4, a);
      chk("R9 aux low", rb[2], 8'hA3);
      chk("R9 new flag survives short read", rb[3], 8'h45);
      do_read(4, a);
      chk("R9 new flag cleared", rb[3], 8'h05);
      pulse_aux(11'h5A3);
      pulse_aux(11'h3C6);
      do_read(4, a);
      chk("R10 aux low second", rb[2], 8'hC6);
      chk("R10 overwrite set", rb[3], 8'hC3);
      do_read(4, a);
      chk("R10 overwrite cleared", rb[3], 8'h03);
   endtask

   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      checks++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      wclk(5);
      rst_n = 1'b1;
      wclk(5);
      t_reset();
      t_read_order();
      t_burst();
      t_wrap();
      t_bad_sub();
      t_addr();
      t_cfg_flag();
      t_aux();
      chk("R11 no SDA change with SCL high", hi_edges, 0);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end
endmodule